// File: doc/BRIEF.md
# Carrier-Synchronous QPSK Modulator with Internal Synthesizer

This block turns a serial bit stream into a digital QPSK waveform. Incoming bits are paired: the first of each pair drives the in-phase branch and the second the quadrature branch, each as a symbol of value +1 or -1. An internal phase-accumulator synthesizer, stepped by a frequency word that may be changed at run time, addresses a sine table. The table gives a sine carrier and, read a quarter turn ahead, a cosine carrier of the same frequency. The in-phase symbol multiplies the cosine and the quadrature symbol multiplies the sine. Both products are added and scaled by 181/256 (about 1/sqrt 2), so the output envelope stays constant.

Symbols change only when the accumulator has wrapped a set number of times (`CYC_PER_SYM` carrier cycles), so every symbol starts on a carrier-cycle boundary. One complete pair can wait while the current symbol plays. The input stalls through `bit_ready` until that pair has been consumed.

Top module: `qpsk_mod`

## Requirements
- R1: While reset is held and in the first cycle after it, `samp_valid` is 0, `samp_data` is 0 and `bit_ready` is 1. The phase accumulator restarts from 0.
- R2: The 32-bit accumulator adds `freq_word` on every clock, and a carry out of bit 31 is a wrap. Its top 10 bits give the phase index p. The sine sample is round(2047*sin(2*pi*p/1024)), rounding half up. The cosine sample is the same table read at (p+256) mod 1024.
- R3: Accepted bits alternate. The first bit of each pair is the in-phase symbol and the second is the quadrature symbol. Bit value 0 means +1 and bit value 1 means -1.
- R4: A bit is accepted on a clock where `bit_valid` and `bit_ready` are both 1. `bit_ready` is 0 exactly while a complete pair waits to be loaded.
- R5: The waiting pair becomes the active symbol only on a wrap that completes `CYC_PER_SYM` wraps since reset or since the previous load point. The new symbol applies from the wrapped phase onward.
- R6: For accumulator value A in cycle k, with active symbols sI and sQ, the sample in cycle k+2 is floor((sI*cos(A) + sQ*sin(A))*181/256).
- R7: If no complete pair waits at a load point, the output goes idle: `samp_valid` is 0 and `samp_data` is 0 until a later load point finds a pair.
- R8: With `freq_word` equal to 0 the accumulator never wraps, so no symbol is ever loaded and `samp_valid` stays 0.
- R9: A change of `freq_word` takes effect on the next clock without resetting the phase or the wrap count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 32 | Phase increment added every clock |
| bit_valid | input | 1 | Input bit offered |
| bit_data | input | 1 | Input bit value |
| bit_ready | output | 1 | Block can take a bit this cycle |
| samp_valid | output | 1 | `samp_data` carries a modulated sample |
| samp_data | output | 12 | Signed output sample, 0 when idle |

## Verification
The hardest case to reach from the ports is a load point, the wrap that ends a symbol, arriving when the pair is missing, half-formed or finished in that same cycle. Whether the output keeps running or goes idle depends on the exact cycle the second bit lands. The bench reaches this by starving the input between pairs and by sweeping frequency words, including non-power-of-two steps, so that wraps fall on many different offsets from the bit arrivals. A cycle-level reference model, run alongside the design, judges every sample.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;
  localparam int unsigned QM_PHASE_W   = 32;
  localparam int unsigned QM_ADDR_W    = 10;
  localparam int unsigned QM_SAMP_W    = 12;
  localparam int unsigned QM_SCALE_NUM = 181;
  localparam int unsigned QM_SCALE_SH  = 8;
  localparam int unsigned QM_CYC_SYM   = 2;
endpackage

// File: rtl/qpsk_phase_acc.sv
module qpsk_phase_acc #(
  parameter int unsigned PHASE_W = qpsk_pkg::QM_PHASE_W,
  parameter int unsigned ADDR_W  = qpsk_pkg::QM_ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] freq_word,
  output logic [ADDR_W-1:0]  phase_addr,
  output logic               wrap
);
  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W:0]   sum;

  assign sum  = {1'b0, acc_q} + {1'b0, freq_word};
  assign wrap = sum[PHASE_W];

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum[PHASE_W-1:0];
  end

  assign phase_addr = acc_q[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/qpsk_sin_rom.sv
module qpsk_sin_rom #(
  parameter int unsigned ADDR_W = qpsk_pkg::QM_ADDR_W,
  parameter int unsigned SAMP_W = qpsk_pkg::QM_SAMP_W
) (
  input  logic                     clk,
  input  logic [ADDR_W-1:0]        sin_addr,
  output logic signed [SAMP_W-1:0] sin_q,
  output logic signed [SAMP_W-1:0] cos_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int          AMP   = (1 << (SAMP_W - 1)) - 1;
  localparam logic [ADDR_W-1:0] QTR = ADDR_W'(DEPTH / 4);
  localparam real         TWO_PI = 6.283185307179586;

  logic signed [SAMP_W-1:0] tbl [DEPTH];
  logic [ADDR_W-1:0]        cos_addr;

  initial begin
    for (int k = 0; k < int'(DEPTH); k++)
      tbl[k] = SAMP_W'($rtoi($floor(real'(AMP) * $sin(TWO_PI * real'(k) / real'(DEPTH)) + 0.5)));
  end

  // quarter turn ahead: the two top index bits advance by 01
  assign cos_addr = sin_addr + QTR;

  always_ff @(posedge clk) begin
    sin_q <= tbl[sin_addr];
    cos_q <= tbl[cos_addr];
  end
endmodule

// File: rtl/qpsk_sym_loader.sv
module qpsk_sym_loader #(
  parameter int unsigned CYC_PER_SYM = qpsk_pkg::QM_CYC_SYM
) (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  output logic sym_act,
  output logic sym_i,
  output logic sym_q
);
  localparam int unsigned CNT_W = (CYC_PER_SYM > 1) ? $clog2(CYC_PER_SYM) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_PER_SYM - 1);

  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             half, first_b;
  logic             pend_full, pend_i, pend_q;
  logic             take;

  assign tick      = wrap && (cnt == CNT_LAST);
  assign bit_ready = !pend_full;
  assign take      = bit_valid && bit_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      half <= 1'b0; first_b <= 1'b0;
      pend_full <= 1'b0; pend_i <= 1'b0; pend_q <= 1'b0;
      sym_act <= 1'b0; sym_i <= 1'b0; sym_q <= 1'b0;
    end else begin
      if (wrap) cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        sym_act   <= pend_full;
        sym_i     <= pend_i;
        sym_q     <= pend_q;
        pend_full <= 1'b0;
      end
      if (take) begin
        if (!half) begin
          first_b <= bit_data;
          half    <= 1'b1;
        end else begin
          pend_i    <= first_b;
          pend_q    <= bit_data;
          pend_full <= 1'b1;
          half      <= 1'b0;
        end
      end
    end
  end

  AST_SYM_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable({sym_act, sym_i, sym_q}) |-> $past(wrap)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_LAST); // R5
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
    pend_full && !wrap |=> !bit_ready); // R4
  AST_PAIR_STALLS: assert property (@(posedge clk) disable iff (rst)
    bit_valid && bit_ready && half |=> !bit_ready); // R4
endmodule

// File: rtl/qpsk_mod.sv
module qpsk_mod #(
  parameter int unsigned PHASE_W     = qpsk_pkg::QM_PHASE_W,
  parameter int unsigned ADDR_W      = qpsk_pkg::QM_ADDR_W,
  parameter int unsigned SAMP_W      = qpsk_pkg::QM_SAMP_W,
  parameter int unsigned SCALE_NUM   = qpsk_pkg::QM_SCALE_NUM,
  parameter int unsigned SCALE_SH    = qpsk_pkg::QM_SCALE_SH,
  parameter int unsigned CYC_PER_SYM = qpsk_pkg::QM_CYC_SYM
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PHASE_W-1:0]       freq_word,
  input  logic                     bit_valid,
  input  logic                     bit_data,
  output logic                     bit_ready,
  output logic                     samp_valid,
  output logic signed [SAMP_W-1:0] samp_data
);
  localparam int unsigned PROD_W = SAMP_W + SCALE_SH + 3;
  localparam logic signed [PROD_W-1:0] SCALE = PROD_W'(SCALE_NUM);

  logic [ADDR_W-1:0]        phase_addr;
  logic                     wrap;
  logic                     sym_act, sym_i, sym_q;
  logic                     act_d, i_d, q_d;
  logic signed [SAMP_W-1:0] sin_q, cos_q;
  logic signed [PROD_W-1:0] c_ext, s_ext, i_term, q_term, prod;
  logic signed [SAMP_W-1:0] mixed;

  qpsk_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .freq_word(freq_word),
    .phase_addr(phase_addr), .wrap(wrap)
  );

  qpsk_sym_loader #(.CYC_PER_SYM(CYC_PER_SYM)) u_load (
    .clk(clk), .rst(rst), .wrap(wrap),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .sym_act(sym_act), .sym_i(sym_i), .sym_q(sym_q)
  );

  qpsk_sin_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
    .clk(clk), .sin_addr(phase_addr), .sin_q(sin_q), .cos_q(cos_q)
  );

  // symbols travel alongside the registered table read
  always_ff @(posedge clk) begin
    if (rst) begin
      act_d <= 1'b0; i_d <= 1'b0; q_d <= 1'b0;
    end else begin
      act_d <= sym_act; i_d <= sym_i; q_d <= sym_q;
    end
  end

  assign c_ext  = PROD_W'(cos_q);
  assign s_ext  = PROD_W'(sin_q);
  assign i_term = i_d ? -c_ext : c_ext;
  assign q_term = q_d ? -s_ext : s_ext;
  assign prod   = (i_term + q_term) * SCALE;
  assign mixed  = SAMP_W'(prod >>> SCALE_SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_valid <= 1'b0;
      samp_data  <= '0;
    end else begin
      samp_valid <= act_d;
      samp_data  <= act_d ? mixed : '0;
    end
  end

  AST_VALID_FOLLOWS_SYM: assert property (@(posedge clk) disable iff (rst)
    samp_valid |-> $past(sym_act, 2)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(act_d) |-> samp_data == '0); // R7
endmodule

// File: tb/qpsk_mod_bench.sv
`timescale 1ns/1ps
module qpsk_mod_bench;
  localparam int NSYM = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] freq_word = '0;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic        bit_ready, samp_valid;
  logic signed [11:0] samp_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;
  int tab [1024];

  always #2.5 clk = ~clk;

  qpsk_mod u_qpsk_mod (
    .clk(clk), .rst(rst), .freq_word(freq_word),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .samp_valid(samp_valid), .samp_data(samp_data)
  );

  // fields: frequency word [47:16], bit pattern LSB first [15:8], bit count [7:0]
  localparam logic [47:0] VEC [6] = '{
    {32'h1000_0000, 8'b1110_0100, 8'd8},
    {32'h0A3D_70A4, 8'hB5,        8'd8},
    {32'h8000_0000, 8'h3C,        8'd8},
    {32'h2000_0000, 8'hFF,        8'd8},
    {32'h1234_5678, 8'h00,        8'd6},
    {32'h4000_0000, 8'h96,        8'd8}
  };

  initial begin
    for (int k = 0; k < 1024; k++)
      tab[k] = $rtoi($floor(2047.0 * $sin(6.283185307179586 * real'(k) / 1024.0) + 0.5));
  end

  function automatic logic signed [11:0] ref_sample(logic [31:0] a, logic si, logic sq);
    int p, c, s, v;
    p = int'(a[31:22]);
    s = tab[p];
    c = tab[(p + 256) % 1024];
    v = (si ? -c : c) + (sq ? -s : s);
    return 12'((v * 181) >>> 8);
  endfunction

  // reference model built from the requirements
  logic [31:0] m_acc;
  logic [1:0]  m_cnt;
  logic m_half, m_first, m_pf, m_pi, m_pq, m_act, m_si, m_sq;
  logic e1v, e2v;
  logic signed [11:0] e1, e2;

  always @(posedge clk) begin
    logic [32:0] nx;
    logic tk;
    if (rst) begin
      m_acc <= '0; m_cnt <= '0; m_half <= 0; m_first <= 0; m_pf <= 0; m_pi <= 0; m_pq <= 0;
      m_act <= 0; m_si <= 0; m_sq <= 0; e1v <= 0; e2v <= 0; e1 <= '0; e2 <= '0;
    end else begin
      nx = {1'b0, m_acc} + {1'b0, freq_word};
      tk = nx[32] && (int'(m_cnt) == NSYM - 1);
      m_acc <= nx[31:0];
      if (nx[32]) m_cnt <= tk ? 2'd0 : m_cnt + 2'd1;
      if (tk) begin m_act <= m_pf; m_si <= m_pi; m_sq <= m_pq; m_pf <= 1'b0; end
      if (bit_valid && !m_pf) begin
        if (!m_half) begin m_first <= bit_data; m_half <= 1'b1; end
        else begin m_pi <= m_first; m_pq <= bit_data; m_pf <= 1'b1; m_half <= 1'b0; end
      end
      e1  <= ref_sample(m_acc, m_si, m_sq);
      e1v <= m_act;
      e2  <= e1;
      e2v <= e1v;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      checks++;
      if (bit_ready !== !m_pf) begin
        errors++; $display("FAIL R4 ready t=%0t got %0b exp %0b", $time, bit_ready, !m_pf);
      end
      checks++;
      if (samp_valid !== e2v) begin
        errors++; $display("FAIL R5 R7 valid t=%0t got %0b exp %0b", $time, samp_valid, e2v);
      end
      checks++;
      if (samp_data !== (e2v ? e2 : 12'sd0)) begin
        errors++; $display("FAIL R6 R2 R3 sample t=%0t got %0d exp %0d", $time, samp_data, e2v ? e2 : 12'sd0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog R1 got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(bit ok, string tag, int got, int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s got %0d exp %0d", tag, got, exp); end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(logic b);
    bit_data = b; bit_valid = 1'b1;
    while (!bit_ready) @(negedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  initial begin
    // R1: reset state
    freq_word = 32'h1000_0000;
    do_reset();
    check(samp_valid == 1'b0, "R1 valid", samp_valid, 0);
    check(samp_data == 12'sd0, "R1 data", samp_data, 0);
    check(bit_ready == 1'b1, "R1 ready", bit_ready, 1);

    // vector table: every sample compared with the model (R2 R3 R4 R5 R6)
    for (int r = 0; r < 6; r++) begin
      freq_word = VEC[r][47:16];
      do_reset();
      cmp_en = 1'b1;
      for (int b = 0; b < int'(VEC[r][7:0]); b++) push(VEC[r][8 + b]);
      repeat (300) @(negedge clk);
      cmp_en = 1'b0;
    end

    // R8: zero frequency word never loads a symbol
    freq_word = 32'h0;
    do_reset();
    cmp_en = 1'b1;
    push(1'b0); push(1'b1);
    repeat (200) @(negedge clk);
    check(samp_valid == 1'b0, "R8 valid", samp_valid, 0);
    check(bit_ready == 1'b0, "R8 R4 ready", bit_ready, 0);
    cmp_en = 1'b0;

    // R7: one pair, then starvation makes the output idle
    freq_word = 32'h4000_0000;
    do_reset();
    cmp_en = 1'b1;
    push(1'b1); push(1'b0);
    repeat (60) @(negedge clk);
    check(samp_valid == 1'b0, "R7 valid", samp_valid, 0);
    check(samp_data == 12'sd0, "R7 data", samp_data, 0);
    cmp_en = 1'b0;

    // R9: frequency change mid-stream, phase carries on
    freq_word = 32'h1000_0000;
    do_reset();
    cmp_en = 1'b1;
    push(1'b0); push(1'b1);
    repeat (37) @(negedge clk);
    freq_word = 32'h0555_5555;
    push(1'b1); push(1'b1); push(1'b0); push(1'b0);
    repeat (300) @(negedge clk);
    cmp_en = 1'b0;

    // R2 R3: half-rate carrier, both symbols -1: samples alternate -1448 and +1447
    freq_word = 32'h8000_0000;
    do_reset();
    push(1'b1); push(1'b1);
    for (int w = 0; w < 40 && !samp_valid; w++) @(negedge clk);
    begin
      int a, b;
      a = samp_data;
      @(negedge clk);
      b = samp_data;
      check((a == -1448 && b == 1447) || (a == 1447 && b == -1448), "R2 R3 first", a, -1448);
      check(a + b == -1, "R2 R3 pair", a + b, -1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule